// File: doc/BRIEF.md
# Register-Pair Immediate Adder

This sequential unit executes one instruction: it adds a 6-bit unsigned immediate to a 16-bit value held as two adjacent bytes in the upper part of an 8-bit register file, and then updates the status byte. The unit accepts a 16-bit opcode together with a start request. It selects one of four byte pairs from the opcode. It works through a single byte-wide read port and a single byte-wide write port of the register file, handling the low byte in the first cycle and the high byte in the second.

The first working cycle reads the low byte, adds the immediate to it, writes the result back and keeps the carry out. The second cycle reads the high byte, adds the kept carry, writes that byte back and publishes the new status byte. The unit shows `busy` for both cycles and `done` in the second one. A start request that arrives while the unit is working is dropped. Instruction fetch and every other opcode belong to the surrounding core.

Top module: `pair_imm_adder`

## Requirements
- R1: A start is accepted only while the unit is idle and `opcode[15:8]` equals 8'h96. A start with any other upper opcode byte causes no register write, no status write and no `busy`.
- R2: The pair index is `p = opcode[5:4]`. The low byte is register 24+2p and the high byte is register 25+2p. The low byte is written in the first busy cycle and the high byte in the second.
- R3: The immediate is `{opcode[7:6], opcode[3:0]}`, zero-extended. The value stored in the pair afterwards is (old pair value + immediate) modulo 65536.
- R4: After an accepted start, `busy` is high for exactly two cycles and `done` is high only in the second of them.
- R5: In the status byte, bit 1 (Z) is set exactly when the 16-bit result is zero. Bit 2 (N) equals result bit 15.
- R6: Bit 3 (V) is set when old bit 15 was 0 and result bit 15 is 1. Bit 0 (C) is set when old bit 15 was 1 and result bit 15 is 0. V and C are never set together.
- R7: Bit 4 (S) equals N xor V. Bits 7:5 of the written status are copied from `sregIn`.
- R8: A start request during either busy cycle is ignored. Its opcode leaves its own pair untouched, and the unit is idle after the second cycle.
- R9: While reset is asserted and in the first cycle after it, `busy`, `done`, `rfWrEn` and `sregWrEn` are low.
- R10: `rfWrEn` is high only while busy. `sregWrEn` is high only together with `done`. While `sregWrEn` is low, `sregOut` equals `sregIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the opcode on `opcode` |
| opcode | input | 16 | Instruction word |
| rfRdData | input | 8 | Register-file read data, combinational for `rfRdAddr` |
| sregIn | input | 8 | Current status byte |
| rfRdAddr | output | 5 | Register-file read address |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrAddr | output | 5 | Register-file write address |
| rfWrData | output | 8 | Register-file write data |
| sregWrEn | output | 1 | Status byte write enable |
| sregOut | output | 8 | New status byte |
| busy | output | 1 | Unit is executing |
| done | output | 1 | Final cycle of execution |

## Verification
Two things can fall in the same cycle: a new start request and the final cycle, in which the high byte and the status are committed and `done` is shown. The bench provokes this by raising start in the first busy cycle, with an opcode that names a different pair, and holding it across the final-cycle edge. It then judges three things: the current operation completes correctly, the other pair keeps its value, and `busy` is low afterwards. The bench also runs operations back to back on the same pair. Each operation must then read the bytes the previous one just wrote.

// File: rtl/pia_pkg.sv
package pia_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } piaState_t;

  typedef struct packed {
    logic latchOp;
    logic wrLow;
    logic wrHigh;
  } piaStrobes_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;

endpackage

// File: rtl/pia_ctrl.sv
module pia_ctrl
  import pia_pkg::*;
#(
  parameter logic [7:0] OPC_HI = 8'h96
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcodeHi,
  output piaStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  piaState_t state, stateNext;
  logic opMatch;

  assign opMatch = (opcodeHi == OPC_HI);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start && opMatch) stateNext = ST_LOW;
      ST_LOW:  stateNext = ST_HIGH;
      ST_HIGH: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.latchOp = (state == ST_IDLE) && start && opMatch;
    strobes.wrLow   = (state == ST_LOW);
    strobes.wrHigh  = (state == ST_HIGH);
  end

  assign busy = (state == ST_LOW) || (state == ST_HIGH);
  assign done = (state == ST_HIGH);

  // R4: the low phase is always followed by the high phase
  a_r4_low_then_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW) |=> (state == ST_HIGH));

  // R8: the high phase returns to idle even when start is held high
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH) |=> !busy);

  // R4: done is only shown while busy
  a_r4_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

// File: rtl/pia_datapath.sv
module pia_datapath
  import pia_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int PAIR_BASE = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  piaStrobes_t       strobes,
  input  logic [7:0]        opcodeLo,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [7:0]        sregIn,
  output logic [ADDR_W-1:0] rfRdAddr,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              sregWrEn,
  output logic [7:0]        sregOut
);

  localparam int IMM_W = 6;
  localparam int MSB   = DATA_W - 1;

  logic [1:0]        pairSel;
  logic [IMM_W-1:0]  immVal;
  logic              carryHold;
  logic              lowZero;
  logic [ADDR_W-1:0] lowAddr;
  logic [DATA_W:0]   lowSum;
  logic [DATA_W-1:0] highSum;
  logic [DATA_W-1:0] wrByte;
  logic              oldTop, newTop;
  logic              flagZ, flagN, flagV, flagC, flagS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairSel   <= '0;
      immVal    <= '0;
      carryHold <= 1'b0;
      lowZero   <= 1'b0;
    end else begin
      if (strobes.latchOp) begin
        pairSel <= opcodeLo[5:4];
        immVal  <= {opcodeLo[7:6], opcodeLo[3:0]};
      end
      if (strobes.wrLow) begin
        carryHold <= lowSum[DATA_W];
        lowZero   <= (lowSum[DATA_W-1:0] == '0);
      end
    end
  end

  assign lowAddr  = ADDR_W'(PAIR_BASE) + ADDR_W'({pairSel, 1'b0});
  assign rfRdAddr = strobes.wrHigh ? (lowAddr + ADDR_W'(1)) : lowAddr;

  assign lowSum  = {1'b0, rfRdData} + (DATA_W + 1)'(immVal);
  assign highSum = rfRdData + DATA_W'(carryHold);

  assign wrByte   = strobes.wrHigh ? highSum : lowSum[DATA_W-1:0];
  assign rfWrEn   = strobes.wrLow | strobes.wrHigh;
  assign rfWrAddr = rfRdAddr;
  assign rfWrData = wrByte;

  assign oldTop = rfRdData[MSB];
  assign newTop = highSum[MSB];
  assign flagZ  = lowZero && (highSum == '0);
  assign flagN  = newTop;
  assign flagV  = !oldTop && newTop;
  assign flagC  = oldTop && !newTop;
  assign flagS  = flagN ^ flagV;

  always_comb begin
    sregOut = sregIn;
    if (strobes.wrHigh) begin
      sregOut[FLAG_C] = flagC;
      sregOut[FLAG_Z] = flagZ;
      sregOut[FLAG_N] = flagN;
      sregOut[FLAG_V] = flagV;
      sregOut[FLAG_S] = flagS;
    end
  end
  assign sregWrEn = strobes.wrHigh;

  // R2: the high byte goes to the register right after the low byte
  a_r2_high_follows_low: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHigh |-> (rfWrAddr == $past(rfWrAddr) + ADDR_W'(1)));

  // R6: overflow and carry exclude each other for an unsigned add
  a_r6_v_c_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    sregWrEn |-> !(sregOut[FLAG_V] && sregOut[FLAG_C]));

  // R2: the low phase addresses an even register inside the pair window
  a_r2_low_even: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLow |-> (rfWrAddr[0] == 1'b0 && rfWrAddr >= ADDR_W'(PAIR_BASE)));

endmodule

// File: rtl/pair_imm_adder.sv
module pair_imm_adder
  import pia_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int PAIR_BASE = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       opcode,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [7:0]        sregIn,
  output logic [ADDR_W-1:0] rfRdAddr,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              sregWrEn,
  output logic [7:0]        sregOut,
  output logic              busy,
  output logic              done
);

  piaStrobes_t strobes;

  pia_ctrl #(.OPC_HI(8'h96)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opcodeHi (opcode[15:8]),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  pia_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PAIR_BASE (PAIR_BASE)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opcodeLo (opcode[7:0]),
    .rfRdData (rfRdData),
    .sregIn   (sregIn),
    .rfRdAddr (rfRdAddr),
    .rfWrEn   (rfWrEn),
    .rfWrAddr (rfWrAddr),
    .rfWrData (rfWrData),
    .sregWrEn (sregWrEn),
    .sregOut  (sregOut)
  );

  // R10: register writes only happen while busy
  a_r10_write_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> busy);

  // R10: status writes coincide with done
  a_r10_sreg_with_done: assert property (@(posedge clk) disable iff (!rstN)
    sregWrEn |-> done);

  // R4: a rising busy lasts into the next cycle
  a_r4_busy_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

endmodule

// File: tb/pair_imm_adder_test.sv
module pair_imm_adder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [7:0]  rfRdData;
  logic [7:0]  sregIn;
  logic [4:0]  rfRdAddr, rfWrAddr;
  logic        rfWrEn, sregWrEn, busy, done;
  logic [7:0]  rfWrData, sregOut;

  logic [7:0] rf [32];
  logic [7:0] sregModel = 8'h00;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pair_imm_adder uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .rfRdData(rfRdData), .sregIn(sregIn), .rfRdAddr(rfRdAddr),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .sregWrEn(sregWrEn), .sregOut(sregOut), .busy(busy), .done(done)
  );

  assign rfRdData = rf[rfRdAddr];
  assign sregIn   = sregModel;

  always @(posedge clk) begin
    if (rfWrEn)   rf[rfWrAddr] <= rfWrData;
    if (sregWrEn) sregModel    <= sregOut;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pairVal(input int p);
    return {rf[25 + 2*p], rf[24 + 2*p]};
  endfunction

  task automatic setPair(input int p, input logic [15:0] v);
    rf[24 + 2*p] = v[7:0];
    rf[25 + 2*p] = v[15:8];
  endtask

  function automatic logic [15:0] mkOp(input int p, input logic [5:0] k);
    return {8'h96, k[5:4], 2'(p), k[3:0]};
  endfunction

  // full operation with all checks; called at a negedge while idle
  task automatic runOp(input int p, input logic [5:0] k, input logic [15:0] base,
                       input logic [7:0] sregStart, input bit preload);
    logic [15:0] res;
    logic n, v, c, z;
    if (preload) begin
      setPair(p, base);
      sregModel = sregStart;
    end
    opcode = mkOp(p, k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 busy first", busy, 1);
    check("R4 done first", done, 0);
    @(negedge clk);
    check("R4 done second", done, 1);
    @(negedge clk);
    check("R4 idle after", busy, 0);
    res = base + 16'(k);
    n = res[15]; v = !base[15] && res[15]; c = base[15] && !res[15]; z = (res == 0);
    check("R3 R2 pair value", pairVal(p), res);
    check("R5 R6 R7 status", sregModel,
          {sregStart[7:5], n ^ v, v, n, z, c});
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 8'(i * 7 + 3);
    @(negedge clk);
    // R9: reset state
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 rfWrEn", rfWrEn, 0);
    check("R9 sregWrEn", sregWrEn, 0);
    @(negedge clk);
    rstN = 1'b1;
    check("R9 after release", {busy, done, rfWrEn, sregWrEn}, 0);
    check("R10 passthrough", sregOut, sregModel);

    // R1: non-matching opcode ignored
    setPair(1, 16'hABCD);
    sregModel = 8'h5A;
    opcode = 16'h9750;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 no busy", busy, 0);
    @(negedge clk);
    check("R1 pair kept", pairVal(1), 16'hABCD);
    check("R1 status kept", sregModel, 8'h5A);

    // R2 R3 R5 R6 R7: sweep pairs, immediates and bases
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 64; k++)
        for (int b = 0; b < 5; b++) begin
          logic [15:0] base;
          case (b)
            0: base = 16'h0000;
            1: base = 16'h7FF0;
            2: base = 16'hFFC5;
            3: base = 16'hFFFF - 16'(k) + 16'd1;
            default: base = 16'h12F3 + 16'(k * 257);
          endcase
          runOp(p, 6'(k), base, {base[2:0], 5'b10101} ^ 8'(k), 1'b1);
        end

    // back to back on the same pair: second op reads first op's result
    setPair(2, 16'h00FE);
    sregModel = 8'h00;
    runOp(2, 6'd3, 16'h00FE, 8'h00, 1'b0);
    runOp(2, 6'd63, 16'h0101, 8'h00, 1'b0);

    // R8: start held through both busy cycles with another pair's opcode
    setPair(0, 16'h7FFF);
    setPair(3, 16'h4444);
    sregModel = 8'hE0;
    opcode = mkOp(0, 6'd1);
    start = 1'b1;
    @(negedge clk);
    opcode = mkOp(3, 6'd9);
    check("R8 busy", busy, 1);
    @(negedge clk);
    check("R8 done", done, 1);
    @(negedge clk);
    start = 1'b0;
    check("R8 not restarted", busy, 0);
    check("R8 other pair kept", pairVal(3), 16'h4444);
    check("R8 R6 overflow result", pairVal(0), 16'h8000);
    check("R8 R6 status", sregModel, 8'hE0 | 8'h0C | 8'h10 ^ 8'h10);
    @(negedge clk);
    check("R8 still idle", busy, 0);
    check("R8 other pair final", pairVal(3), 16'h4444);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule